// File: doc/BRIEF.md
# Dual Tick Timer

This peripheral gives a small 4-bit controller two counters that advance on a shared tick. A prescaler divides the system clock by a fixed ratio to make that tick. The first counter is a 7-bit free-running counter with a fixed period of 127 ticks. It raises its interrupt flag each time it comes back to zero. The second counter is 8 bits wide and only runs while it is enabled. On overflow it reloads itself from a holding register, raises its own flag and inverts a toggle output.

The CPU side works in nibbles. A byte is put together from a high and a low nibble input. Three write strobes store that byte:
- into the first counter,
- into the reload register alone,
- into the second counter and the reload register together.

A select input chooses which of the three values appears on the two read nibble outputs. A 4-bit control register holds:
- the interrupt enables (bit 0 for the first timer, bit 1 for the second),
- the run enable of the second counter (bit 3).

Each flag stays set until its clear pulse arrives. Each interrupt request is the flag gated by its enable.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, both counts, the reload register, the control register, both flags, both requests and the toggle output are 0.
- R2: The tick fires once every 6 clock cycles, starting right after reset. Both counters change only on a tick cycle or on a CPU write.
- R3: On each tick the first counter increments. When it is at 126, the tick takes it to 0 and sets the first flag. A count of 127, which can only come from a load, goes to 0 on the next tick without setting the flag.
- R4: The second counter increments on a tick only while control bit 3 is 1. Otherwise it holds its value.
- R5: On an enabled tick at 255, the second counter does three things:
  - it takes the reload value,
  - it sets the second flag,
  - it inverts the toggle output.
- R6: A load byte is {high nibble, low nibble}. The write strobes act as follows:
  - the first-counter strobe stores the low 7 bits of the byte;
  - the reload strobe changes only the reload register;
  - the combined strobe writes the same byte into both the second counter and the reload register.
- R7: The read select picks the source: 0 gives the first count, zero-extended; 1 gives the second count; 2 gives the reload value; 3 gives 0. The low nibble of the chosen value goes on the low read output and the high nibble on the high read output, with no clock delay.
- R8: A write that lands on a tick cycle takes priority over the increment. The tick phase is left undisturbed.
- R9: A flag holds until its clear input is pulsed. When a set and a clear fall in the same cycle, the set wins.
- R10: The first request is its flag AND control bit 0. The second request is its flag AND control bit 1. The control register is written whole by its strobe and is visible on an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nib_lo_i | input | 4 | Low nibble of the load byte |
| nib_hi_i | input | 4 | High nibble of the load byte |
| wr_t1_i | input | 1 | Store the byte into the first counter |
| wr_rl_i | input | 1 | Store the byte into the reload register only |
| wr_t2_i | input | 1 | Store the byte into the second counter and the reload register |
| rd_sel_i | input | 2 | Read source select |
| rd_lo_o | output | 4 | Low nibble of the selected value |
| rd_hi_o | output | 4 | High nibble of the selected value |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_i | input | 4 | Control register data |
| ctrl_o | output | 4 | Control register contents |
| clr_t1_i | input | 1 | Clear pulse for the first flag |
| clr_t2_i | input | 1 | Clear pulse for the second flag |
| t1_flag_o | output | 1 | First timer flag |
| t2_flag_o | output | 1 | Second timer flag |
| t1_irq_o | output | 1 | First timer request |
| t2_irq_o | output | 1 | Second timer request |
| tog_o | output | 1 | Output inverted on each second-counter overflow |

## Verification
The bench loads 126 into the first counter to check the short wrap. A design that wraps at 128 would show 127 instead of 0 and would raise no flag. It also loads 127 to check that this value wraps without a flag; a design that compares the wrong value would flag it. It times a write so that it lands exactly on a tick. A design that lets the increment win would show the loaded value plus one, and a design that restarts the prescaler would shift the next step. It holds a clear across the tick that sets a flag, and stops the second counter while a load is made. These catch a clear-wins flag, a counter that runs while disabled, and an overflow that goes to 0 instead of to the reload value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_T1   = 2'd0,
    SEL_T2   = 2'd1,
    SEL_RL   = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;

  localparam int CTRL_W      = 4;
  localparam int CB_T1_IRQEN = 0;
  localparam int CB_T2_IRQEN = 1;
  localparam int CB_T2_RUN   = 3;
endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);

  // R2: ticks never come back to back
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/fixed_counter.sv
module fixed_counter #(
  parameter int W      = 7,
  parameter int PERIOD = 127
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] count_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (ld_i) begin
      cnt_d = ld_val_i;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        wrap  = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
  assign wrap_o  = wrap;

  // R2: no tick and no load means the count holds
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !ld_i) |=> $stable(cnt_q));
  // R3: the last count in the period goes back to zero
  p_t1_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ld_i && cnt_q == LAST) |=> (cnt_q == '0));
  // R8: a load wins over the tick
  p_t1_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (cnt_q == $past(ld_val_i)));
endmodule

// File: rtl/reload_counter.sv
module reload_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic         ld_cnt_i,
  input  logic         ld_rl_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] reload_o,
  output logic         wrap_o,
  output logic         tog_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d, rl_q, rl_d;
  logic         tog_q, tog_d, wrap;

  always_comb begin
    cnt_d = cnt_q;
    rl_d  = rl_q;
    tog_d = tog_q;
    wrap  = 1'b0;
    if (ld_rl_i || ld_cnt_i) rl_d = ld_val_i;
    if (ld_cnt_i) begin
      cnt_d = ld_val_i;
    end else if (tick_i && en_i) begin
      if (&cnt_q) begin
        cnt_d = rl_q;
        wrap  = 1'b1;
        tog_d = ~tog_q;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rl_q  <= '0;
      tog_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rl_q  <= rl_d;
      tog_q <= tog_d;
    end
  end

  assign count_o  = cnt_q;
  assign reload_o = rl_q;
  assign wrap_o   = wrap;
  assign tog_o    = tog_q;

  // R4: a stopped counter holds its value
  p_t2_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !ld_cnt_i) |=> $stable(cnt_q));
  // R5: overflow takes the reload value and flips the toggle output
  p_t2_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && en_i && !ld_cnt_i && !ld_rl_i && (&cnt_q))
      |=> (cnt_q == $past(rl_q)) && (tog_q != $past(tog_q)));
  // R6: the reload-only strobe leaves the count alone
  p_rl_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rl_i && !ld_cnt_i && !tick_i) |=> (rl_q == $past(ld_val_i)) && $stable(cnt_q));
endmodule

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R9: a flag holds until it is cleared
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  // R9: a set wins over a clear in the same cycle
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer #(
  parameter int TICK_DIV  = 6,
  parameter int NIB_W     = 4,
  parameter int T1_W      = 7,
  parameter int T1_PERIOD = 127
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NIB_W-1:0]          nib_lo_i,
  input  logic [NIB_W-1:0]          nib_hi_i,
  input  logic                      wr_t1_i,
  input  logic                      wr_rl_i,
  input  logic                      wr_t2_i,
  input  logic [1:0]                rd_sel_i,
  output logic [NIB_W-1:0]          rd_lo_o,
  output logic [NIB_W-1:0]          rd_hi_o,
  input  logic                      ctrl_wr_i,
  input  logic [tmr_pkg::CTRL_W-1:0] ctrl_i,
  output logic [tmr_pkg::CTRL_W-1:0] ctrl_o,
  input  logic                      clr_t1_i,
  input  logic                      clr_t2_i,
  output logic                      t1_flag_o,
  output logic                      t2_flag_o,
  output logic                      t1_irq_o,
  output logic                      t2_irq_o,
  output logic                      tog_o
);
  import tmr_pkg::*;

  localparam int BW = 2 * NIB_W;

  logic [BW-1:0]      ld_byte, t2_cnt, t2_rl, rd_val;
  logic [T1_W-1:0]    t1_cnt;
  logic [CTRL_W-1:0]  ctrl_q, ctrl_d;
  logic               tick, t1_wrap, t2_wrap;

  assign ld_byte = {nib_hi_i, nib_lo_i};

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr_i) ctrl_d = ctrl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  fixed_counter #(.W(T1_W), .PERIOD(T1_PERIOD)) u_t1 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ld_i(wr_t1_i),
    .ld_val_i(ld_byte[T1_W-1:0]), .count_o(t1_cnt), .wrap_o(t1_wrap)
  );

  reload_counter #(.W(BW)) u_t2 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(ctrl_q[CB_T2_RUN]),
    .ld_cnt_i(wr_t2_i), .ld_rl_i(wr_rl_i), .ld_val_i(ld_byte),
    .count_o(t2_cnt), .reload_o(t2_rl), .wrap_o(t2_wrap), .tog_o(tog_o)
  );

  irq_flag u_f1 (
    .clk(clk), .rst_n(rst_n), .set_i(t1_wrap), .clr_i(clr_t1_i), .flag_o(t1_flag_o)
  );

  irq_flag u_f2 (
    .clk(clk), .rst_n(rst_n), .set_i(t2_wrap), .clr_i(clr_t2_i), .flag_o(t2_flag_o)
  );

  always_comb begin
    case (rd_sel_e'(rd_sel_i))
      SEL_T1:  rd_val = BW'(t1_cnt);
      SEL_T2:  rd_val = t2_cnt;
      SEL_RL:  rd_val = t2_rl;
      default: rd_val = '0;
    endcase
  end

  assign rd_lo_o  = rd_val[NIB_W-1:0];
  assign rd_hi_o  = rd_val[BW-1:NIB_W];
  assign ctrl_o   = ctrl_q;
  assign t1_irq_o = t1_flag_o & ctrl_q[CB_T1_IRQEN];
  assign t2_irq_o = t2_flag_o & ctrl_q[CB_T2_IRQEN];

  // R10: a request needs both its flag and its enable
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_irq_o |-> (t1_flag_o && ctrl_q[CB_T1_IRQEN])) and
    (t2_irq_o |-> (t2_flag_o && ctrl_q[CB_T2_IRQEN])));
  // R5: the toggle output changes only together with a second-timer flag set
  p_tog_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_o != $past(tog_o)) |-> t2_flag_o);
endmodule

// File: tb/dual_tick_timer_test.sv
module dual_tick_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] nib_lo = '0, nib_hi = '0, ctrl_in = '0;
  logic       wr_t1 = 0, wr_rl = 0, wr_t2 = 0, ctrl_wr = 0, clr1 = 0, clr2 = 0;
  logic [1:0] sel = '0;
  logic [3:0] rd_lo, rd_hi, ctrl_out;
  logic       f1, f2, irq1, irq2, tog;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dual_tick_timer uut (
    .clk(clk), .rst_n(rst_n), .nib_lo_i(nib_lo), .nib_hi_i(nib_hi),
    .wr_t1_i(wr_t1), .wr_rl_i(wr_rl), .wr_t2_i(wr_t2), .rd_sel_i(sel),
    .rd_lo_o(rd_lo), .rd_hi_o(rd_hi), .ctrl_wr_i(ctrl_wr), .ctrl_i(ctrl_in),
    .ctrl_o(ctrl_out), .clr_t1_i(clr1), .clr_t2_i(clr2), .t1_flag_o(f1),
    .t2_flag_o(f2), .t1_irq_o(irq1), .t2_irq_o(irq2), .tog_o(tog)
  );

  // vector: op[19:18] (1 t1, 2 reload, 3 t2+reload), hi, lo, sel, expected byte
  localparam logic [19:0] VEC [7] = '{
    {2'd1, 4'hA, 4'h5, 2'd0, 8'h25},
    {2'd3, 4'h3, 4'hC, 2'd1, 8'h3C},
    {2'd3, 4'h3, 4'hC, 2'd2, 8'h3C},
    {2'd2, 4'h9, 4'h1, 2'd2, 8'h91},
    {2'd2, 4'h9, 4'h1, 2'd1, 8'h3C},
    {2'd1, 4'hF, 4'hF, 2'd0, 8'h7F},
    {2'd1, 4'h0, 4'h0, 2'd3, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd();
    return {rd_hi, rd_lo};
  endfunction

  task automatic load(input int op, input logic [7:0] b);
    @(negedge clk);
    {nib_hi, nib_lo} = b;
    wr_t1 = (op == 1); wr_rl = (op == 2); wr_t2 = (op == 3);
    @(negedge clk);
    wr_t1 = 0; wr_rl = 0; wr_t2 = 0;
  endtask

  task automatic set_ctrl(input logic [3:0] v);
    @(negedge clk); ctrl_in = v; ctrl_wr = 1;
    @(negedge clk); ctrl_wr = 0;
  endtask

  // waits at negedges until the selected value changes; returns cycles waited
  task automatic wait_change(output int n);
    logic [7:0] old;
    old = rd();
    n = 0;
    while (rd() == old && n < 2000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    sel = 2'd1; #0 check("R1 t2", rd(), 8'h00);
    sel = 2'd2; #0 check("R1 reload", rd(), 8'h00);
    check("R1 flags/irq/tog/ctrl", {f1, f2, irq1, irq2, tog, ctrl_out}, '0);

    // table of load and read-back vectors (R6, R7)
    foreach (VEC[i]) begin
      load(int'(VEC[i][19:18]), VEC[i][17:10]);
      sel = VEC[i][9:8];
      #0 check("R6/R7 vector", rd(), VEC[i][7:0]);
    end

    // R2 tick spacing seen on the first counter
    sel = 2'd0;
    @(negedge clk);
    wait_change(n);
    wait_change(n);
    check("R2 tick period", n, 6);

    // R4 stopped second counter holds
    set_ctrl(4'h0);
    load(3, 8'h10);
    sel = 2'd1;
    repeat (20) @(negedge clk);
    check("R4 held while stopped", rd(), 8'h10);
    set_ctrl(4'h8);
    wait_change(n);
    check("R4 runs when enabled", rd(), 8'h11);

    // R5 overflow to reload, flag, toggle; R6 reload-only write
    set_ctrl(4'h0);
    load(3, 8'hFE);
    load(2, 8'h40);
    check("R6 count untouched by reload write", rd(), 8'hFE);
    set_ctrl(4'h8);
    wait_change(n);
    check("R5 step to FF", rd(), 8'hFF);
    check("R5 no flag before overflow", {f2, tog}, 2'b00);
    wait_change(n);
    check("R5 count takes reload", rd(), 8'h40);
    check("R5 flag and toggle", {f2, tog}, 2'b11);
    check("R10 t2 request masked", irq2, 1'b0);
    set_ctrl(4'hA);
    check("R10 t2 request enabled", irq2, 1'b1);
    @(negedge clk); clr2 = 1; @(negedge clk); clr2 = 0;
    check("R9 t2 flag cleared", {f2, irq2}, 2'b00);
    set_ctrl(4'h0);

    // R3 short wrap with flag, set wins over a held clear (R9)
    sel = 2'd0;
    load(1, 8'h7E);
    clr1 = 1;
    wait_change(n);
    check("R3 wraps 126 to 0", rd(), 8'h00);
    check("R9 set beats clear", f1, 1'b1);
    clr1 = 0;
    repeat (3) @(negedge clk);
    check("R9 flag holds", f1, 1'b1);
    check("R10 t1 request masked", irq1, 1'b0);
    set_ctrl(4'h1);
    check("R10 t1 request enabled", irq1, 1'b1);
    @(negedge clk); clr1 = 1; @(negedge clk); clr1 = 0;
    check("R9 t1 flag cleared", f1, 1'b0);

    // R3 loaded 127 wraps silently
    load(1, 8'h7F);
    wait_change(n);
    check("R3 127 wraps to 0", rd(), 8'h00);
    check("R3 no flag from 127", f1, 1'b0);

    // R8 write on the tick cycle wins, phase kept
    wait_change(n);
    repeat (5) @(negedge clk);
    {nib_hi, nib_lo} = 8'h30; wr_t1 = 1;
    @(negedge clk); wr_t1 = 0;
    check("R8 load beats tick", rd(), 8'h30);
    repeat (5) @(negedge clk);
    check("R8 holds until next tick", rd(), 8'h30);
    @(negedge clk);
    check("R8 phase kept", rd(), 8'h31);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule